// File: doc/BRIEF.md
# Double-Buffered Event Histogram Memory

This block turns a stream of position events from a linear detector into a histogram. It holds two identical count banks. One bank faces the detector. For each event the detector drives a 9-bit position and pulls an active-low ready line low. The block then adds one to the count at that position and raises an acknowledge, so the detector can begin its next conversion.

The other bank faces a controller. The controller drains it one word per cycle. Each read returns the stored count one cycle later and writes zero back to that word. A separate step control moves the drain pointer forward, so a read and a step can share one cycle. When a frame ends, a swap pulse exchanges the roles of the two banks. The bank just filled becomes available for draining, and the bank just emptied starts collecting the next frame.

Counts saturate at their maximum value instead of wrapping. A sticky flag records that saturation has occurred.

Top module: `evt_hist_pingpong`

## Requirements
- R1: After reset every count in both banks is zero, bank 0 faces the detector (`act_bank_o`=0), and `det_ack_o`, `rd_valid_o` and `ovf_o` are low. The drain pointer is 0.
- R2: A high-to-low transition on `det_rdy_ni` adds one to the count at `det_addr_i` in the bank facing the detector. `det_ack_o` then rises within 10 clock cycles of the transition.
- R3: `det_ack_o` stays high while `det_rdy_ni` stays low. It falls within 4 cycles after `det_rdy_ni` returns high.
- R4: A count equal to 2^CNT_W-1 (16'hFFFF by default) stays at that value when another event hits it, and `ovf_o` goes high. Once set, `ovf_o` stays high until reset.
- R5: A one-cycle pulse on `swap_i` while no event is being processed inverts `act_bank_o` on the next clock edge.
- R6: If an event is detected in the same cycle as a swap pulse, or while an increment is in progress, the event is counted in the bank that faced the detector before the swap. The swap takes effect after that increment.
- R7: With `rd_en_i` high in a cycle, the cycle after it shows `rd_valid_o` high and `rd_data_o` equal to the count at `rd_addr_o` in the bank not facing the detector.
- R8: Each such read writes zero to the word it read, so a later read of that word returns 0.
- R9: `rd_inc_i` advances `rd_addr_o` by one, wrapping from 511 to 0. `rd_rewind_i` sets it to 0 and takes priority over `rd_inc_i`.
- R10: Holding `rd_en_i` and `rd_inc_i` high together streams consecutive words with one valid result in every cycle.
- R11: Detector events never change the bank that is not facing the detector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| det_rdy_ni | input | 1 | Detector event strobe, active low; an event is its falling edge |
| det_addr_i | input | ADDR_W | Event position |
| det_ack_o | output | 1 | Increment done; held until the strobe is released |
| swap_i | input | 1 | Exchange the detector bank and the drain bank |
| rd_en_i | input | 1 | Read and clear the drain bank at the drain pointer |
| rd_inc_i | input | 1 | Advance the drain pointer |
| rd_rewind_i | input | 1 | Set the drain pointer to 0 |
| rd_data_o | output | CNT_W | Read data, valid one cycle after `rd_en_i` |
| rd_valid_o | output | 1 | `rd_data_o` holds a read result |
| rd_addr_o | output | ADDR_W | Current drain pointer |
| act_bank_o | output | 1 | Index of the bank facing the detector |
| ovf_o | output | 1 | Sticky saturation flag |

## Verification
The assertions assume the detector holds `det_rdy_ni` low until it sees the acknowledge, and does not lower it again until the acknowledge has dropped. They also assume `det_addr_i` stays stable for the whole time the strobe is low. The bench drives each event through one task that follows this handshake exactly. That task changes the position only while the strobe is high. Swap pulses are one cycle wide. Drain reads are issued only from the controller side, so no write to the drain bank ever comes from outside the block.

// File: rtl/hist_pkg.sv
package hist_pkg;
  typedef enum logic [1:0] {
    ENG_IDLE = 2'd0,
    ENG_INC  = 2'd1,
    ENG_ACK  = 2'd2
  } eng_st_e;
endpackage

// File: rtl/hist_bank.sv
module hist_bank #(
  parameter int AW = 9,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] ra_i,
  output logic [DW-1:0] rd_o,
  input  logic          we_i,
  input  logic [AW-1:0] wa_i,
  input  logic [DW-1:0] wd_i
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  assign rd_o = mem_q[ra_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[wa_i] <= wd_i;
    end
  end
endmodule

// File: rtl/hist_inc_engine.sv
module hist_inc_engine
  import hist_pkg::*;
#(
  parameter int AW = 9,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rdy_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] rdata_i,
  output logic [AW-1:0] addr_o,
  output logic          we_o,
  output logic [DW-1:0] wd_o,
  output logic          ack_o,
  output logic          lock_o,
  output logic          ovf_o
);
  logic    s1_q, s2_q, s3_q;
  logic    fall;
  logic    sat;
  eng_st_e st_q;
  logic [AW-1:0] addr_q;
  logic    ovf_q;

  // two-stage synchronizer plus one delayed copy for edge detection
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
      s3_q <= 1'b1;
    end else begin
      s1_q <= rdy_ni;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign fall = s3_q & ~s2_q;
  assign sat  = (rdata_i == {DW{1'b1}});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ENG_IDLE;
      addr_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      unique case (st_q)
        ENG_IDLE: if (fall) begin
          addr_q <= addr_i;
          st_q   <= ENG_INC;
        end
        ENG_INC: begin
          if (sat) ovf_q <= 1'b1;
          st_q <= ENG_ACK;
        end
        ENG_ACK: if (s2_q) st_q <= ENG_IDLE;
        default: st_q <= ENG_IDLE;
      endcase
    end
  end

  assign addr_o = addr_q;
  assign we_o   = (st_q == ENG_INC);
  assign wd_o   = sat ? rdata_i : rdata_i + 1'b1;
  assign ack_o  = (st_q == ENG_ACK);
  assign lock_o = fall | (st_q == ENG_INC);
  assign ovf_o  = ovf_q;

  p_ack_after_inc_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_o) |-> $past(we_o));
  p_no_wrap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |-> (wd_o != '0));
  p_ovf_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o);
  p_ack_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && !s2_q) |=> ack_o);
endmodule

// File: rtl/hist_drain.sv
module hist_drain #(
  parameter int AW = 9,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_en_i,
  input  logic          inc_i,
  input  logic          rewind_i,
  input  logic [DW-1:0] rdata_i,
  output logic [AW-1:0] addr_o,
  output logic          we_o,
  output logic [DW-1:0] data_o,
  output logic          valid_o
);
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic          valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= rd_en_i;
      if (rd_en_i) data_q <= rdata_i;
      if (rewind_i)   addr_q <= '0;
      else if (inc_i) addr_q <= addr_q + 1'b1;
    end
  end

  assign addr_o  = addr_q;
  assign we_o    = rd_en_i;  // clear-on-read
  assign data_o  = data_q;
  assign valid_o = valid_q;

  p_rd_latency_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> valid_o);
  p_addr_step_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !rewind_i) |=> (addr_o == $past(addr_o) + 1'b1));
  p_rewind_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rewind_i |=> (addr_o == '0));
endmodule

// File: rtl/evt_hist_pingpong.sv
module evt_hist_pingpong #(
  parameter int ADDR_W = 9,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              det_rdy_ni,
  input  logic [ADDR_W-1:0] det_addr_i,
  output logic              det_ack_o,
  input  logic              swap_i,
  input  logic              rd_en_i,
  input  logic              rd_inc_i,
  input  logic              rd_rewind_i,
  output logic [CNT_W-1:0]  rd_data_o,
  output logic              rd_valid_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              act_bank_o,
  output logic              ovf_o
);
  localparam int NBANK = 2;

  logic              act_q, swap_pend_q, swap_want;
  logic              eng_lock, eng_we, drn_we;
  logic [ADDR_W-1:0] eng_addr, drn_addr;
  logic [CNT_W-1:0]  eng_wd, eng_rd, drn_rd;

  logic [ADDR_W-1:0] bank_ra [NBANK];
  logic [CNT_W-1:0]  bank_rd [NBANK];
  logic              bank_we [NBANK];
  logic [CNT_W-1:0]  bank_wd [NBANK];

  // a swap waits while an increment is pending so the event hits the old bank
  assign swap_want = swap_i | swap_pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q       <= 1'b0;
      swap_pend_q <= 1'b0;
    end else if (swap_want && !eng_lock) begin
      act_q       <= ~act_q;
      swap_pend_q <= 1'b0;
    end else begin
      swap_pend_q <= swap_want;
    end
  end

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    logic is_act;
    assign is_act     = (act_q == g[0]);
    assign bank_ra[g] = is_act ? eng_addr : drn_addr;
    assign bank_we[g] = is_act ? eng_we : drn_we;
    assign bank_wd[g] = is_act ? eng_wd : '0;

    hist_bank #(.AW(ADDR_W), .DW(CNT_W)) u_bank (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .ra_i   (bank_ra[g]),
      .rd_o   (bank_rd[g]),
      .we_i   (bank_we[g]),
      .wa_i   (bank_ra[g]),
      .wd_i   (bank_wd[g])
    );
  end

  assign eng_rd = bank_rd[act_q];
  assign drn_rd = bank_rd[~act_q];

  hist_inc_engine #(.AW(ADDR_W), .DW(CNT_W)) u_eng (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rdy_ni  (det_rdy_ni),
    .addr_i  (det_addr_i),
    .rdata_i (eng_rd),
    .addr_o  (eng_addr),
    .we_o    (eng_we),
    .wd_o    (eng_wd),
    .ack_o   (det_ack_o),
    .lock_o  (eng_lock),
    .ovf_o   (ovf_o)
  );

  hist_drain #(.AW(ADDR_W), .DW(CNT_W)) u_drn (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_en_i  (rd_en_i),
    .inc_i    (rd_inc_i),
    .rewind_i (rd_rewind_i),
    .rdata_i  (drn_rd),
    .addr_o   (drn_addr),
    .we_o     (drn_we),
    .data_o   (rd_data_o),
    .valid_o  (rd_valid_o)
  );

  assign rd_addr_o  = drn_addr;
  assign act_bank_o = act_q;

  p_swap_held_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_lock |=> $stable(act_q));
  p_swap_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (swap_i && !eng_lock) |=> (act_q != $past(act_q)));
endmodule

// File: tb/evt_hist_pingpong_bench.sv
module evt_hist_pingpong_bench;
  localparam int AW    = 9;
  localparam int CW    = 4;
  localparam int DEPTH = 1 << AW;
  localparam int CMAX  = (1 << CW) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic det_rdy_n = 1'b1, swap = 1'b0, rd_en = 1'b0, rd_inc = 1'b0, rd_rew = 1'b0;
  logic [AW-1:0] det_addr = '0;
  logic det_ack, rd_valid, act_bank, ovf;
  logic [CW-1:0] rd_data;
  logic [AW-1:0] rd_addr;

  int n_chk = 0, n_fail = 0;
  int mdl [2][DEPTH];
  int mact = 0, maddr = 0;
  int exp_q [$];
  string tag_q [$];

  always #2 clk = ~clk;

  evt_hist_pingpong #(.ADDR_W(AW), .CNT_W(CW)) u_evt_hist_pingpong (
    .clk_i(clk), .rst_ni(rst_n), .det_rdy_ni(det_rdy_n), .det_addr_i(det_addr),
    .det_ack_o(det_ack), .swap_i(swap), .rd_en_i(rd_en), .rd_inc_i(rd_inc),
    .rd_rewind_i(rd_rew), .rd_data_o(rd_data), .rd_valid_o(rd_valid),
    .rd_addr_o(rd_addr), .act_bank_o(act_bank), .ovf_o(ovf)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: pop expected drain words as results appear
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) chk(1'b0, "R7", int'(rd_data), -1);
      else begin
        int e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(int'(rd_data) == e, t, int'(rd_data), e);
      end
    end
  end

  task automatic fire_event(input int a, input bit with_swap);
    int cnt;
    @(negedge clk);
    det_addr  = AW'(a);
    det_rdy_n = 1'b0;
    cnt = 0;
    // R2: the counted bank is the one facing the detector now (R6 when swapping)
    mdl[mact][a] = (mdl[mact][a] == CMAX) ? CMAX : mdl[mact][a] + 1;
    if (with_swap) begin
      @(negedge clk); cnt++;
      @(negedge clk); cnt++;
      swap = 1'b1;
      @(negedge clk); cnt++;
      swap = 1'b0;
      mact ^= 1;
    end
    while (!det_ack && cnt < 20) begin
      @(negedge clk); cnt++;
    end
    chk(det_ack && cnt <= 10, "R2", cnt, 10);
    @(negedge clk);
    chk(det_ack == 1'b1, "R3", int'(det_ack), 1);
    det_rdy_n = 1'b1;
    cnt = 0;
    while (det_ack && cnt < 20) begin
      @(negedge clk); cnt++;
    end
    chk(!det_ack && cnt <= 4, "R3", cnt, 4);
    @(negedge clk);
  endtask

  task automatic do_swap();
    @(negedge clk);
    swap = 1'b1;
    @(negedge clk);
    swap = 1'b0;
    mact ^= 1;
    chk(int'(act_bank) == mact, "R5", int'(act_bank), mact);
  endtask

  task automatic rewind();
    @(negedge clk);
    rd_rew = 1'b1; rd_inc = 1'b1;
    @(negedge clk);
    rd_rew = 1'b0; rd_inc = 1'b0;
    maddr = 0;
    chk(int'(rd_addr) == 0, "R9", int'(rd_addr), 0);
  endtask

  task automatic skip(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rd_inc = 1'b1;
      maddr = (maddr + 1) % DEPTH;
    end
    @(negedge clk);
    rd_inc = 1'b0;
  endtask

  task automatic drain(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rd_en = 1'b1; rd_inc = 1'b1;
      exp_q.push_back(mdl[mact ^ 1][maddr]);
      tag_q.push_back(tag);
      mdl[mact ^ 1][maddr] = 0;
      maddr = (maddr + 1) % DEPTH;
    end
    @(negedge clk);
    rd_en = 1'b0; rd_inc = 1'b0;
    @(negedge clk);
    chk(int'(rd_addr) == maddr, "R9", int'(rd_addr), maddr);
  endtask

  initial begin
    for (int b = 0; b < 2; b++)
      for (int i = 0; i < DEPTH; i++) mdl[b][i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(act_bank == 1'b0, "R1", int'(act_bank), 0);
    chk(det_ack == 1'b0, "R1", int'(det_ack), 0);
    chk(rd_valid == 1'b0, "R1", int'(rd_valid), 0);
    chk(ovf == 1'b0, "R1", int'(ovf), 0);
    chk(int'(rd_addr) == 0, "R1", int'(rd_addr), 0);
    drain(4, "R1");  // drain bank 1 from reset: zeros

    rewind();
    repeat (3) fire_event(5, 1'b0);
    fire_event(0, 1'b0);
    repeat (2) fire_event(511, 1'b0);
    do_swap();
    rewind();
    drain(8, "R10");                 // R7/R10 streaming counts of bank 0
    rewind();
    drain(8, "R8");                  // second pass returns zeros
    skip(503);
    drain(2, "R9");                  // 511 then wrap to 0

    fire_event(100, 1'b0);           // lands in bank 1 only
    rewind();
    skip(100);
    drain(1, "R11");                 // bank 0 word 100 still zero

    fire_event(9, 1'b1);             // R6: coincident swap, counts in bank 1
    chk(int'(act_bank) == mact, "R6", int'(act_bank), mact);
    rewind();
    skip(9);
    drain(1, "R6");
    skip(90);
    drain(1, "R6");

    for (int i = 0; i < CMAX; i++) fire_event(3, 1'b0);
    chk(ovf == 1'b0, "R4", int'(ovf), 0);
    fire_event(3, 1'b0);
    chk(ovf == 1'b1, "R4", int'(ovf), 1);
    do_swap();
    rewind();
    skip(3);
    drain(1, "R4");
    chk(ovf == 1'b1, "R4", int'(ovf), 1);

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R7", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule